// File: doc/BRIEF.md
# Bit-Stuffing Serial Command Transmitter

This block turns an 8-bit command word into a two-wire serial frame, a data line and a clock line, for a receiver that samples data on the rising clock edge. A single-cycle start strobe loads the word. The block then shifts it out least significant bit first. The serial clock is derived from the system clock by a parameterised divider. Data moves only on the falling serial-clock edge, so it is steady around every rising edge.

While the payload goes out, the block counts consecutive ones. After a third one in a row it inserts a zero bit, whatever the next payload bit is. A zero resets the count, whether it is a payload zero or an inserted stuff bit. After the payload, a six-bit trailer 0,1,1,1,1,0 is sent with stuffing suppressed. Its run of four ones therefore cannot appear anywhere else in the frame, and it marks the end of the frame. The frame length varies with the payload: 8 data bits, plus 0 to 2 stuff bits, plus 6 trailer bits.

The controller has four states:
- IDLE: the clock and data lines are held low.
- DATA: one payload bit is being sent.
- STUFF: an inserted zero is being sent.
- FRAME: one trailer bit is being sent.

Transitions happen only on a start strobe (IDLE to DATA) or on a falling serial-clock edge:
- DATA to STUFF when the bit just sent completes a run of three ones.
- DATA to FRAME, or STUFF to FRAME, once the last payload bit is done.
- DATA to DATA, or STUFF to DATA, otherwise.
- FRAME to FRAME until the sixth trailer bit is done, then FRAME to IDLE.

Top module: `stuff_cmd_tx`

## Requirements
- R1: After reset, sclk, sdata, busy and done are all low.
- R2: Payload bits are transmitted least significant bit first, one bit per serial-clock period; the receiver reads each bit at the rising sclk edge.
- R3: After every run of three consecutive transmitted ones in the payload, a 0 bit is inserted, whether the next payload bit is 1 or 0 and also after the last payload bit; any transmitted zero, stuffed or not, restarts the run count.
- R4: After the payload (and any stuff bit following it), the six bits 0,1,1,1,1,0 are transmitted in that order with no stuffing.
- R5: sdata changes only in the same cycle that sclk falls, and is stable for the whole time sclk is high.
- R6: Each serial-clock period lasts 2*HALF system clocks, with sclk high for exactly HALF of them.
- R7: busy rises in the cycle after a start strobe accepted in IDLE, and stays high for exactly 2*HALF*(14 + stuff bits) system clocks, falling together with the last sclk fall of the trailer.
- R8: done is a single-cycle pulse, issued in the cycle where busy has just fallen.
- R9: A start strobe while busy is ignored: the frame in progress, its length and its done pulse are unchanged.
- R10: While idle, sclk and sdata stay low and no sclk edges occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send cmd |
| cmd | input | DATA_W | Command word, captured when start is accepted |
| busy | output | 1 | High while a frame is being transmitted |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sclk | output | 1 | Generated serial clock, idle low |
| sdata | output | 1 | Serial data, changes on falling sclk |

## Verification
The transmitter is tried with several kinds of payload:
- All zeros and words with no run of three ones show that no stray stuff bits are added.
- All ones and 0x77 / 0xEE separate correct run counting from a counter that fails to restart after a stuff bit.
- Words ending in three ones (0xE0) check that a stuff bit is still sent just before the trailer.
- Words starting with three ones (0x07) check the first-bit case.

Random words from a seeded generator cover the rest. A start strobe injected mid-frame shows that requests while busy leave the frame intact.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_STUFF = 2'd2,
        ST_FRAME = 2'd3
    } stx_state_e;

    localparam int FRAME_LEN = 6;
    // bit 0 is transmitted first; pattern 0,1,1,1,1,0
    localparam logic [FRAME_LEN-1:0] FRAME_WORD = 6'b011110;

endpackage

// File: rtl/stx_sclk_gen.sv
module stx_sclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == LAST);
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stx_run_track.sv
module stx_run_track #(
    parameter int RUN_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic bit_in,
    output logic stuff_due
);
    localparam int RW = $clog2(RUN_LIMIT + 1);
    localparam logic [RW-1:0] NEAR = RW'(RUN_LIMIT - 1);

    logic [RW-1:0] run_cnt;

    assign stuff_due = step && bit_in && (run_cnt == NEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clear) begin
            run_cnt <= '0;
        end else if (step) begin
            if (!bit_in || stuff_due) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift,
    output logic              cur_bit,
    output logic              nxt_bit,
    output logic              last_bit,
    output logic              empty
);
    localparam int IW = $clog2(DATA_W + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);
    localparam logic [IW-1:0] END_IDX  = IW'(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [IW-1:0]     idx;

    assign cur_bit  = shreg[0];
    assign nxt_bit  = (DATA_W > 1) ? shreg[1] : 1'b0;
    assign last_bit = (idx == LAST_IDX);
    assign empty    = (idx == END_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (load) begin
            shreg <= din;
            idx   <= '0;
        end else if (shift) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/stuff_cmd_tx.sv
module stuff_cmd_tx
    import stx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HALF      = 2,
    parameter int RUN_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] cmd,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sdata
);
    localparam int FW = $clog2(FRAME_LEN);
    localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_LEN - 1);

    stx_state_e state, state_nx;

    logic          fall_tick;
    logic          accept;
    logic          cur_bit, nxt_bit, last_bit, empty;
    logic          stuff_due;
    logic          trk_step, trk_bit;
    logic          shift_en;
    logic [FW-1:0] fidx;

    assign busy     = (state != ST_IDLE);
    assign accept   = (state == ST_IDLE) && start;
    assign shift_en = fall_tick && (state == ST_DATA);
    assign trk_step = fall_tick && ((state == ST_DATA) || (state == ST_STUFF));
    assign trk_bit  = (state == ST_DATA) ? cur_bit : 1'b0;

    stx_sclk_gen #(.HALF(HALF)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .sclk      (sclk),
        .fall_tick (fall_tick)
    );

    stx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .din      (cmd),
        .shift    (shift_en),
        .cur_bit  (cur_bit),
        .nxt_bit  (nxt_bit),
        .last_bit (last_bit),
        .empty    (empty)
    );

    stx_run_track #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (trk_step),
        .bit_in    (trk_bit),
        .stuff_due (stuff_due)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (fall_tick) begin
                    if (stuff_due)     state_nx = ST_STUFF;
                    else if (last_bit) state_nx = ST_FRAME;
                    else               state_nx = ST_DATA;
                end
            end
            ST_STUFF: begin
                if (fall_tick) begin
                    if (empty) state_nx = ST_FRAME;
                    else       state_nx = ST_DATA;
                end
            end
            ST_FRAME: begin
                if (fall_tick && (fidx == FRAME_LAST)) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs: serial data, trailer index and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata <= 1'b0;
            done  <= 1'b0;
            fidx  <= '0;
        end else begin
            done <= (state == ST_FRAME) && fall_tick && (fidx == FRAME_LAST);
            if (accept) begin
                sdata <= cmd[0];
            end else if (fall_tick) begin
                unique case (state_nx)
                    ST_DATA: sdata <= (state == ST_DATA) ? nxt_bit : cur_bit;
                    ST_STUFF: sdata <= 1'b0;
                    ST_FRAME: begin
                        if (state == ST_FRAME) begin
                            fidx  <= fidx + 1'b1;
                            sdata <= FRAME_WORD[fidx + 1'b1];
                        end else begin
                            fidx  <= '0;
                            sdata <= FRAME_WORD[0];
                        end
                    end
                    default: begin
                        sdata <= 1'b0;
                        fidx  <= '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/stx_tx_checker.sv
module stx_tx_checker #(
    parameter int HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sdata
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt <= '0;
        else if (sclk) hi_cnt <= hi_cnt + 1'b1;
        else hi_cnt <= '0;
    end

    a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    a_r6_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt == 16'(HALF)));

    a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r10_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdata));
endmodule

bind stuff_cmd_tx stx_tx_checker #(.HALF(HALF)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .sdata (sdata)
);

// File: tb/sim_stuff_cmd_tx.sv
module sim_stuff_cmd_tx;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic       busy, done, sclk, sdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stuff_cmd_tx #(.DATA_W(8), .HALF(HALF), .RUN_LIMIT(3)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .busy(busy), .done(done), .sclk(sclk), .sdata(sdata)
    );

    // monitor state
    bit          mon_on = 0;
    logic [31:0] got_bits;
    int          got_n, busy_cyc, done_cnt, hi_run;
    bit          hi_bad, stab_bad, done_ok;
    logic        prev_sclk = 1'b0, prev_sdata = 1'b0, prev_busy = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) busy_cyc++;
            if (done) begin
                done_cnt++;
                if (busy || !prev_busy) done_ok = 0;
            end
            if (sclk && !prev_sclk && got_n < 32) begin
                got_bits[got_n] = sdata;
                got_n++;
            end
            if (sclk && prev_sclk && (sdata != prev_sdata)) stab_bad = 1;
            if (sclk) hi_run++;
            else begin
                if (prev_sclk && hi_run != HALF) hi_bad = 1;
                hi_run = 0;
            end
        end
        prev_sclk  = sclk;
        prev_sdata = sdata;
        prev_busy  = busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int build_frame(input logic [7:0] c, output logic [31:0] b);
        int n = 0;
        int run = 0;
        logic [5:0] trl = 6'b011110;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            b[n] = c[i];
            n++;
            run = c[i] ? run + 1 : 0;
            if (run == 3) begin
                b[n] = 1'b0;
                n++;
                run = 0;
            end
        end
        for (int i = 0; i < 6; i++) begin
            b[n] = trl[i];
            n++;
        end
        return n;
    endfunction

    task automatic send(input logic [7:0] c, input int inject_at, input logic [7:0] c2);
        logic [31:0] exp_b;
        int          exp_n;
        int          waited;
        exp_n = build_frame(c, exp_b);
        @(negedge clk); #1;
        got_bits = '0; got_n = 0; busy_cyc = 0; done_cnt = 0; hi_run = 0;
        hi_bad = 0; stab_bad = 0; done_ok = 1; mon_on = 1;
        start = 1'b1; cmd = c;
        @(negedge clk); #1;
        start = 1'b0; cmd = 8'h00;
        waited = 0;
        while (done_cnt == 0 && waited < 2000) begin
            if (waited == inject_at) begin
                start = 1'b1; cmd = c2;   // R9: request while busy
            end
            @(negedge clk); #1;
            start = 1'b0;
            waited++;
        end
        repeat (3) @(negedge clk);
        #1;
        mon_on = 0;
        // R2 R3 R4: bit stream and its length
        chk(got_n == exp_n, "R3", $sformatf("frame length cmd=%02h", c), got_n, exp_n);
        chk(got_bits == exp_b, "R2/R4", $sformatf("bit stream cmd=%02h", c), got_bits, exp_b);
        chk(busy_cyc == 2 * HALF * exp_n, "R7", "busy duration", busy_cyc, 2 * HALF * exp_n);
        chk(done_cnt == 1 && done_ok, "R8", "done pulse count", done_cnt, 1);
        chk(!stab_bad, "R5", "sdata stable while sclk high", stab_bad, 0);
        chk(!hi_bad, "R6", "sclk high phase length", hi_bad, 0);
    endtask

    task automatic idle_check();
        bit seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sclk || sdata || busy) seen = 1;
        end
        chk(!seen, "R10", "idle lines quiet", seen, 0);
    endtask

    initial begin
        logic [7:0] dir[6] = '{8'h00, 8'hFF, 8'h77, 8'hEE, 8'h07, 8'hE0};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({sclk, sdata, busy, done} == 4'b0, "R1", "reset outputs",
            {sclk, sdata, busy, done}, 0);
        #1 rst_n = 1'b1;
        idle_check();
        foreach (dir[i]) send(dir[i], -1, 8'h00);
        // R9: start while busy is ignored
        send(8'hA5, 10, 8'hFF);
        send(8'h3C, 40, 8'h00);
        idle_check();
        for (int i = 0; i < 24; i++) begin
            send(8'($urandom), -1, 8'h00);
        end
        idle_check();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule